// File: doc/BRIEF.md
# Cuckoo-Hashed Miss Status Table

This block records the cache lines that a non-blocking cache has already asked external memory for. Each record holds a line tag and a pointer to the first row of that line's pending-request list. The records are kept in several small hash tables, and each table is indexed by its own hash of the tag. A small stash holds records that have not yet found a home. An incoming miss is compared with one slot per table and with every stash entry, all in the same cycle. If the tag is found nowhere, the miss is primary: a record is written and one memory request leaves the block. If the tag is found, the miss is secondary: the stored pointer is returned so that the caller can add its request to that list, and no memory request is made.

When every candidate slot of a new tag is taken, the record is still accepted and parked in the stash. In cycles that carry neither a new miss nor a memory response, a relocation engine takes one stash entry and tries to place it. It moves the entry into a free candidate slot if one exists. Otherwise it displaces the occupant of one table into the stash, in cuckoo fashion. The number of displacements in one chain is bounded. A memory response looks up its tag, returns the stored pointer one cycle later and frees the record. Requests stall only while a response is presented or while the stash is full.

Top module: `miss_cuckoo_table`

## Requirements
- R1: After reset, req_ready is high, cls_valid, mem_valid and rel_valid are low, and the table holds no record, so the first request for any tag is primary.
- R2: An accepted request whose tag is held nowhere produces, on the following cycle, cls_valid=1 with cls_primary=1 and cls_ptr equal to the request's req_ptr. In the same cycle mem_valid=1 with mem_tag equal to the request tag.
- R3: An accepted request whose tag is already held produces, on the following cycle, cls_valid=1 with cls_primary=0 and cls_ptr equal to the pointer stored by that tag's primary miss. mem_valid stays low.
- R4: A held tag is found whether its record sits in any of the hash tables or in the stash, and each tag is held in at most one place.
- R5: A primary miss whose candidate slots are all occupied is still accepted while the stash has room. The block never holds more than NUM_WAYS*2^IDX_W + STASH_DEPTH records.
- R6: Records are relocated only in cycles with neither an accepted request nor a response. One displacement chain makes at most MAX_KICKS moves, after which the record waits in the stash. No relocation loses a record.
- R7: req_ready is low in every cycle in which rsp_valid is high or the stash is full. A request and a response never complete in the same cycle.
- R8: A response for a held tag produces, on the following cycle, rel_valid=1 with rel_found=1 and rel_ptr equal to the stored pointer. The record is freed, so the next request for that tag is primary.
- R9: A response for a tag that is not held produces rel_valid=1 with rel_found=0 and leaves every held record in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A cache miss is presented |
| req_ready | output | 1 | The miss is taken this cycle |
| req_tag | input | TAG_W | Line tag of the miss |
| req_ptr | input | PTR_W | First list row to store if the miss turns out primary |
| cls_valid | output | 1 | Classification result of the miss accepted in the previous cycle |
| cls_primary | output | 1 | 1 = primary miss, 0 = secondary miss |
| cls_ptr | output | PTR_W | List pointer of the record the miss belongs to |
| mem_valid | output | 1 | One memory request for a line |
| mem_tag | output | TAG_W | Tag of the requested line |
| rsp_valid | input | 1 | A memory response returns |
| rsp_tag | input | TAG_W | Tag of the returned line |
| rel_valid | output | 1 | Result of the response seen in the previous cycle |
| rel_found | output | 1 | The response matched a held record, which is now freed |
| rel_ptr | output | PTR_W | List pointer of the freed record |

## Verification
The bench fills the table back-to-back, with no idle cycles, until the stash overflows and requests stall. It then checks that fewer than capacity-plus-stash misses were taken. Next it lets the relocation engine run and answers every accepted tag. Each answer must return its original pointer: a design that dropped a displaced occupant, or that missed records still in the stash, would report not-found or a stale pointer. Other tests present a response and a request in the same cycle, repeat a tag right after its record was freed, and send a response for an absent tag. These catch a design that takes the request during the response, that still reports a secondary miss after the record was freed, or that disturbs other records on a failed lookup.

// File: rtl/mst_pkg.sv
package mst_pkg;

  parameter int TAG_W = 16;
  parameter int PTR_W = 8;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    tag_t tag;
    ptr_t ptr;
  } line_t;

  // Per-table salt: golden-ratio multiple, low bits kept (TAG_W <= 32).
  function automatic tag_t mst_salt(int unsigned way);
    logic [31:0] s;
    s = 32'h9E37_79B1 * (way + 1);
    return s[TAG_W-1:0];
  endfunction

  // XOR with the table salt, then rotate by a table-specific amount.
  function automatic tag_t mst_mix(tag_t t, int unsigned way);
    tag_t x;
    tag_t y;
    int unsigned r;
    x = t ^ mst_salt(way);
    r = (way * 5 + 3) % TAG_W;
    y = '0;
    for (int i = 0; i < TAG_W; i++) begin
      y[(i + r) % TAG_W] = x[i];
    end
    return y;
  endfunction

endpackage

// File: rtl/mst_rst_sync.sv
module mst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/mst_way.sv
module mst_way
  import mst_pkg::*;
#(
  parameter int WAY_ID = 0,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup port (request or response tag)
  input  tag_t             key_tag,
  output logic [IDX_W-1:0] key_idx,
  output logic             key_occ,
  output logic             key_hit,
  output ptr_t             key_ptr,
  // relocation engine port
  input  tag_t             eng_tag,
  output logic [IDX_W-1:0] eng_idx,
  output logic             eng_occ,
  output line_t            eng_line,
  // single write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  line_t            wr_line
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int NCHUNK = (TAG_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  function automatic logic [IDX_W-1:0] slot_of(tag_t t);
    logic [PAD_W-1:0] p;
    logic [IDX_W-1:0] f;
    p = '0;
    p[TAG_W-1:0] = mst_mix(t, WAY_ID);
    f = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      f = f ^ p[c*IDX_W +: IDX_W];
    end
    return f;
  endfunction

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  line_t            line_q [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = wr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_vld) line_q[wr_idx] <= wr_line;
  end

  always_comb begin
    key_idx  = slot_of(key_tag);
    key_occ  = vld_q[key_idx];
    key_hit  = key_occ && (line_q[key_idx].tag == key_tag);
    key_ptr  = line_q[key_idx].ptr;
    eng_idx  = slot_of(eng_tag);
    eng_occ  = vld_q[eng_idx];
    eng_line = line_q[eng_idx];
  end

endmodule

// File: rtl/mst_stash.sv
module mst_stash
  import mst_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int MAX_KICKS = 6,
  parameter int KICK_W    = 3,
  parameter int WAY_W     = 2,
  parameter int SLOT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  // associative search
  input  tag_t              key_tag,
  output logic              key_hit,
  output logic [SLOT_W-1:0] key_slot,
  output ptr_t              key_ptr,
  // relocation scan read
  input  logic [SLOT_W-1:0] scan_slot,
  output logic              scan_vld,
  output line_t             scan_line,
  output logic [KICK_W-1:0] scan_kicks,
  output logic [WAY_W-1:0]  scan_last,
  // occupancy
  output logic              full,
  output logic [SLOT_W-1:0] free_slot,
  // single write port
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_vld,
  input  line_t             wr_line,
  input  logic [KICK_W-1:0] wr_kicks,
  input  logic [WAY_W-1:0]  wr_last
);

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  vld_d;
  line_t             line_q  [DEPTH];
  logic [KICK_W-1:0] kicks_q [DEPTH];
  logic [WAY_W-1:0]  last_q  [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_slot] = wr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_vld) begin
      line_q[wr_slot]  <= wr_line;
      kicks_q[wr_slot] <= wr_kicks;
      last_q[wr_slot]  <= wr_last;
    end
  end

  always_comb begin
    key_hit  = 1'b0;
    key_slot = '0;
    key_ptr  = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (vld_q[s] && (line_q[s].tag == key_tag)) begin
        key_hit  = 1'b1;
        key_slot = SLOT_W'(s);
        key_ptr  = line_q[s].ptr;
      end
    end
  end

  always_comb begin
    full      = &vld_q;
    free_slot = '0;
    for (int s = DEPTH - 1; s >= 0; s--) begin
      if (!vld_q[s]) free_slot = SLOT_W'(s);
    end
  end

  assign scan_vld   = vld_q[scan_slot];
  assign scan_line  = line_q[scan_slot];
  assign scan_kicks = kicks_q[scan_slot];
  assign scan_last  = last_q[scan_slot];

  AST_KICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_vld) |-> (wr_kicks <= KICK_W'(MAX_KICKS))); // R6
  AST_PUSH_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_vld && (wr_kicks == '0)) |-> !vld_q[wr_slot]); // R5

endmodule

// File: rtl/miss_cuckoo_table.sv
module miss_cuckoo_table
  import mst_pkg::*;
#(
  parameter int NUM_WAYS    = 3,
  parameter int IDX_W       = 4,
  parameter int STASH_DEPTH = 4,
  parameter int MAX_KICKS   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [PTR_W-1:0] req_ptr,
  output logic             cls_valid,
  output logic             cls_primary,
  output logic [PTR_W-1:0] cls_ptr,
  output logic             mem_valid,
  output logic [TAG_W-1:0] mem_tag,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             rel_valid,
  output logic             rel_found,
  output logic [PTR_W-1:0] rel_ptr
);

  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int KICK_W = $clog2(MAX_KICKS + 1);
  localparam int SLOT_W = (STASH_DEPTH > 1) ? $clog2(STASH_DEPTH) : 1;

  logic rst_sn;

  mst_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // ---------------- shared lookup key ----------------
  tag_t key_tag;
  assign key_tag = rsp_valid ? rsp_tag : req_tag;

  // ---------------- hash tables ----------------
  logic [NUM_WAYS-1:0] w_key_occ;
  logic [NUM_WAYS-1:0] w_key_hit;
  logic [NUM_WAYS-1:0] w_eng_occ;
  logic [NUM_WAYS-1:0] w_wr_en;
  logic [IDX_W-1:0]    w_key_idx [NUM_WAYS];
  logic [IDX_W-1:0]    w_eng_idx [NUM_WAYS];
  logic [IDX_W-1:0]    w_wr_idx  [NUM_WAYS];
  ptr_t                w_key_ptr [NUM_WAYS];
  line_t               w_eng_line [NUM_WAYS];
  logic                w_wr_vld;
  line_t               w_wr_line;

  // ---------------- stash ----------------
  logic              st_key_hit;
  logic [SLOT_W-1:0] st_key_slot;
  ptr_t              st_key_ptr;
  logic [SLOT_W-1:0] scan_q;
  logic [SLOT_W-1:0] scan_d;
  logic              st_scan_vld;
  line_t             st_scan_line;
  logic [KICK_W-1:0] st_scan_kicks;
  logic [WAY_W-1:0]  st_scan_last;
  logic              st_full;
  logic [SLOT_W-1:0] st_free_slot;
  logic              st_wr_en;
  logic [SLOT_W-1:0] st_wr_slot;
  logic              st_wr_vld;
  line_t             st_wr_line;
  logic [KICK_W-1:0] st_wr_kicks;
  logic [WAY_W-1:0]  st_wr_last;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    mst_way #(.WAY_ID(g), .IDX_W(IDX_W)) u_way (
      .clk      (clk),
      .rst_n    (rst_sn),
      .key_tag  (key_tag),
      .key_idx  (w_key_idx[g]),
      .key_occ  (w_key_occ[g]),
      .key_hit  (w_key_hit[g]),
      .key_ptr  (w_key_ptr[g]),
      .eng_tag  (st_scan_line.tag),
      .eng_idx  (w_eng_idx[g]),
      .eng_occ  (w_eng_occ[g]),
      .eng_line (w_eng_line[g]),
      .wr_en    (w_wr_en[g]),
      .wr_idx   (w_wr_idx[g]),
      .wr_vld   (w_wr_vld),
      .wr_line  (w_wr_line)
    );
  end

  mst_stash #(
    .DEPTH(STASH_DEPTH), .MAX_KICKS(MAX_KICKS), .KICK_W(KICK_W),
    .WAY_W(WAY_W), .SLOT_W(SLOT_W)
  ) u_stash (
    .clk        (clk),
    .rst_n      (rst_sn),
    .key_tag    (key_tag),
    .key_hit    (st_key_hit),
    .key_slot   (st_key_slot),
    .key_ptr    (st_key_ptr),
    .scan_slot  (scan_q),
    .scan_vld   (st_scan_vld),
    .scan_line  (st_scan_line),
    .scan_kicks (st_scan_kicks),
    .scan_last  (st_scan_last),
    .full       (st_full),
    .free_slot  (st_free_slot),
    .wr_en      (st_wr_en),
    .wr_slot    (st_wr_slot),
    .wr_vld     (st_wr_vld),
    .wr_line    (st_wr_line),
    .wr_kicks   (st_wr_kicks),
    .wr_last    (st_wr_last)
  );

  // ---------------- lookup reduction ----------------
  logic             any_hit;
  ptr_t             hit_ptr;
  logic             key_free_found;
  logic [WAY_W-1:0] key_free_way;
  logic             eng_free_found;
  logic [WAY_W-1:0] eng_free_way;
  logic [WAY_W-1:0] kick_way;
  logic [SLOT_W-1:0] scan_next;
  logic             req_fire;

  always_comb begin
    hit_ptr = st_key_ptr;
    for (int g = 0; g < NUM_WAYS; g++) begin
      if (w_key_hit[g]) hit_ptr = w_key_ptr[g];
    end
    any_hit = (|w_key_hit) | st_key_hit;

    key_free_found = 1'b0;
    key_free_way   = '0;
    eng_free_found = 1'b0;
    eng_free_way   = '0;
    for (int g = NUM_WAYS - 1; g >= 0; g--) begin
      if (!w_key_occ[g]) begin
        key_free_found = 1'b1;
        key_free_way   = WAY_W'(g);
      end
      if (!w_eng_occ[g]) begin
        eng_free_found = 1'b1;
        eng_free_way   = WAY_W'(g);
      end
    end

    kick_way  = (st_scan_last == WAY_W'(NUM_WAYS - 1)) ? '0 : st_scan_last + 1'b1;
    scan_next = (scan_q == SLOT_W'(STASH_DEPTH - 1)) ? '0 : scan_q + 1'b1;
  end

  assign req_ready = !rsp_valid && !st_full;
  assign req_fire  = req_valid && req_ready;

  // ---------------- write steering ----------------
  always_comb begin
    w_wr_en     = '0;
    w_wr_vld    = 1'b1;
    w_wr_line   = '{tag: req_tag, ptr: req_ptr};
    for (int g = 0; g < NUM_WAYS; g++) w_wr_idx[g] = w_key_idx[g];
    st_wr_en    = 1'b0;
    st_wr_slot  = st_free_slot;
    st_wr_vld   = 1'b1;
    st_wr_line  = '{tag: req_tag, ptr: req_ptr};
    st_wr_kicks = '0;
    st_wr_last  = WAY_W'(NUM_WAYS - 1);
    scan_d      = scan_q;

    if (rsp_valid) begin
      // free the matching record
      if (|w_key_hit) begin
        w_wr_en  = w_key_hit;
        w_wr_vld = 1'b0;
      end else if (st_key_hit) begin
        st_wr_en   = 1'b1;
        st_wr_slot = st_key_slot;
        st_wr_vld  = 1'b0;
      end
    end else if (req_fire) begin
      // primary miss: first free candidate, else stash
      if (!any_hit) begin
        if (key_free_found) w_wr_en[key_free_way] = 1'b1;
        else                st_wr_en = 1'b1;
      end
    end else begin
      // idle cycle: one relocation step on the scanned stash entry
      for (int g = 0; g < NUM_WAYS; g++) w_wr_idx[g] = w_eng_idx[g];
      w_wr_line = st_scan_line;
      if (!st_scan_vld) begin
        scan_d = scan_next;
      end else if (eng_free_found) begin
        w_wr_en[eng_free_way] = 1'b1;
        st_wr_en   = 1'b1;
        st_wr_slot = scan_q;
        st_wr_vld  = 1'b0;
        scan_d     = scan_next;
      end else if (st_scan_kicks < KICK_W'(MAX_KICKS)) begin
        w_wr_en[kick_way] = 1'b1;
        st_wr_en    = 1'b1;
        st_wr_slot  = scan_q;
        st_wr_line  = w_eng_line[kick_way];
        st_wr_kicks = st_scan_kicks + 1'b1;
        st_wr_last  = kick_way;
      end else begin
        scan_d = scan_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) scan_q <= '0;
    else         scan_q <= scan_d;
  end

  // ---------------- result registers ----------------
  logic cls_valid_d;
  logic mem_valid_d;
  logic rel_valid_d;
  logic cls_primary_d;
  ptr_t cls_ptr_d;

  always_comb begin
    cls_valid_d   = req_fire;
    mem_valid_d   = req_fire && !any_hit;
    rel_valid_d   = rsp_valid;
    cls_primary_d = !any_hit;
    cls_ptr_d     = any_hit ? hit_ptr : req_ptr;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cls_valid <= 1'b0;
      mem_valid <= 1'b0;
      rel_valid <= 1'b0;
    end else begin
      cls_valid <= cls_valid_d;
      mem_valid <= mem_valid_d;
      rel_valid <= rel_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      cls_primary <= cls_primary_d;
      cls_ptr     <= cls_ptr_d;
      mem_tag     <= req_tag;
    end
    if (rsp_valid) begin
      rel_found <= any_hit;
      rel_ptr   <= hit_ptr;
    end
  end

  AST_MEM_ONLY_PRIMARY: assert property (@(posedge clk) disable iff (!rst_sn) mem_valid |-> (cls_valid && cls_primary)); // R2
  AST_SECONDARY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_sn) (cls_valid && !cls_primary) |-> !mem_valid); // R3
  AST_SINGLE_HOME: assert property (@(posedge clk) disable iff (!rst_sn) $countones({w_key_hit, st_key_hit}) <= 1); // R4
  AST_NO_RESULT_OVERLAP: assert property (@(posedge clk) disable iff (!rst_sn) !(cls_valid && rel_valid)); // R7
  AST_FREED_ON_RSP: assert property (@(posedge clk) disable iff (!rst_sn) (rel_valid && rel_found && (key_tag == $past(rsp_tag))) |-> !any_hit); // R8

endmodule

// File: tb/miss_cuckoo_table_test.sv
module miss_cuckoo_table_test;

  localparam int CLK_PERIOD = 10;
  localparam int CAPACITY   = 3 * 16 + 4;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_tag;
  logic [7:0]  req_ptr;
  logic        cls_valid;
  logic        cls_primary;
  logic [7:0]  cls_ptr;
  logic        mem_valid;
  logic [15:0] mem_tag;
  logic        rsp_valid;
  logic [15:0] rsp_tag;
  logic        rel_valid;
  logic        rel_found;
  logic [7:0]  rel_ptr;

  miss_cuckoo_table uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag), .req_ptr(req_ptr),
    .cls_valid(cls_valid), .cls_primary(cls_primary), .cls_ptr(cls_ptr),
    .mem_valid(mem_valid), .mem_tag(mem_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rel_valid(rel_valid), .rel_found(rel_found), .rel_ptr(rel_ptr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [15:0] tag;
    logic [7:0]  ptr;
    bit          primary;
    string       rq;
  } exp_t;

  exp_t        cls_q[$];
  exp_t        rel_q[$];
  logic [7:0]  model [logic [15:0]];
  logic [15:0] acc_tags[$];
  int          checks = 0;
  int          errors = 0;
  bit          mon_on = 1'b0;
  bit          done   = 1'b0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver: present a miss, record the expected classification on acceptance
  task automatic do_req(input logic [15:0] tag, input logic [7:0] ptr, input int wait_max,
                        output bit ok, output int waited);
    exp_t e;
    ok = 1'b0;
    waited = 0;
    req_valid = 1'b1;
    req_tag = tag;
    req_ptr = ptr;
    while (!ok && waited < wait_max) begin
      #1;
      if (req_ready) begin
        e.tag = tag;
        if (model.exists(tag)) begin
          e.primary = 1'b0; e.ptr = model[tag]; e.rq = "R3";
        end else begin
          e.primary = 1'b1; e.ptr = ptr; e.rq = "R2"; model[tag] = ptr;
        end
        cls_q.push_back(e);
        ok = 1'b1;
      end
      @(negedge clk);
      if (!ok) waited++;
    end
    req_valid = 1'b0;
  endtask

  task automatic req_once(input logic [15:0] tag, input logic [7:0] ptr, input string rq);
    bit ok;
    int w;
    do_req(tag, ptr, 50, ok, w);
    check(ok, $sformatf("%s request 0x%h not accepted: actual ready=0 expected 1", rq, tag));
  endtask

  // driver: present a response, R7 says requests are stalled meanwhile
  task automatic do_rsp(input logic [15:0] tag, input string rq);
    exp_t e;
    rsp_valid = 1'b1;
    rsp_tag = tag;
    #1;
    check(req_ready == 1'b0, $sformatf("R7 req_ready during response: actual %0b expected 0", req_ready));
    e.tag = tag;
    e.rq = rq;
    if (model.exists(tag)) begin
      e.primary = 1'b1; e.ptr = model[tag]; model.delete(tag);
    end else begin
      e.primary = 1'b0; e.ptr = '0;
    end
    rel_q.push_back(e);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      if (cls_valid) begin
        if (cls_q.size() == 0) begin
          check(1'b0, $sformatf("R7 unexpected classification: actual cls_valid=1 expected 0"));
        end else begin
          e = cls_q.pop_front();
          check(cls_primary === e.primary && cls_ptr === e.ptr,
                $sformatf("%s tag 0x%h: actual primary=%0b ptr=0x%h expected primary=%0b ptr=0x%h",
                          e.rq, e.tag, cls_primary, cls_ptr, e.primary, e.ptr));
          check(mem_valid === e.primary && (!e.primary || mem_tag === e.tag),
                $sformatf("%s memory request for 0x%h: actual valid=%0b tag=0x%h expected valid=%0b",
                          e.rq, e.tag, mem_valid, mem_tag, e.primary));
        end
      end else if (mem_valid) begin
        check(1'b0, $sformatf("R2 memory request without miss: actual mem_valid=1 expected 0"));
      end
      if (rel_valid) begin
        if (rel_q.size() == 0) begin
          check(1'b0, "R8 unexpected release: actual rel_valid=1 expected 0");
        end else begin
          e = rel_q.pop_front();
          check(rel_found === e.primary && (!e.primary || rel_ptr === e.ptr),
                $sformatf("%s response 0x%h: actual found=%0b ptr=0x%h expected found=%0b ptr=0x%h",
                          e.rq, e.tag, rel_found, rel_ptr, e.primary, e.ptr));
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int w;
    int accepted;
    bit stalled;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_tag = '0;
    req_ptr = '0;
    rsp_valid = 1'b0;
    rsp_tag = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    check(req_ready === 1'b1 && cls_valid === 1'b0 && mem_valid === 1'b0 && rel_valid === 1'b0,
          $sformatf("R1 reset outputs: actual ready=%0b cls=%0b mem=%0b rel=%0b expected 1 0 0 0",
                    req_ready, cls_valid, mem_valid, rel_valid));
    mon_on = 1'b1;

    // R2 / R3 / R8 / R9 basics
    req_once(16'h1234, 8'h05, "R1");
    req_once(16'h1234, 8'h09, "R3");
    req_once(16'h0042, 8'h11, "R2");
    do_rsp(16'h1234, "R8");
    do_rsp(16'h1234, "R9");
    do_rsp(16'h0999, "R9");
    req_once(16'h0042, 8'h33, "R9");   // still held after absent responses
    req_once(16'h1234, 8'h07, "R8");   // freed tag is primary again

    // R7: response and request together, request must wait
    req_valid = 1'b1;
    req_tag = 16'h5555;
    req_ptr = 8'h44;
    do_rsp(16'h0042, "R8");
    req_once(16'h5555, 8'h44, "R7");
    do_rsp(16'h5555, "R8");
    do_rsp(16'h1234, "R8");
    idle(3);

    // R4: moderate fill with idle gaps, then secondary hits everywhere
    for (int i = 0; i < 30; i++) begin
      req_once(16'(i * 16'h0B37 + 16'h2001), 8'(i + 16), "R2");
      idle(2);
    end
    idle(20);
    for (int i = 0; i < 30; i++) req_once(16'(i * 16'h0B37 + 16'h2001), 8'hEE, "R4");
    for (int i = 0; i < 30; i++) do_rsp(16'(i * 16'h0B37 + 16'h2001), "R4");

    // R5 / R7: back-to-back fill until the stash overflows
    accepted = 0;
    stalled = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (!stalled) begin
        do_req(16'(i * 16'h03B1 + 16'h4000), 8'(i + 64), 40, ok, w);
        if (ok) begin
          accepted++;
          acc_tags.push_back(16'(i * 16'h03B1 + 16'h4000));
        end else begin
          stalled = 1'b1;
        end
      end
    end
    check(stalled, $sformatf("R7 stall on full stash: actual stalled=%0b expected 1", stalled));
    check(accepted <= CAPACITY, $sformatf("R5 records held: actual %0d expected <= %0d", accepted, CAPACITY));
    check(accepted >= 3 * 16 / 2, $sformatf("R5 records held: actual %0d expected >= %0d", accepted, 24));

    // R6: relocation during idle cycles loses nothing
    idle(60);
    foreach (acc_tags[k]) do_rsp(acc_tags[k], "R6");
    do_rsp(acc_tags[0], "R9");
    req_once(acc_tags[0], 8'h3C, "R8");
    do_rsp(acc_tags[0], "R8");

    idle(5);
    check(cls_q.size() == 0 && rel_q.size() == 0,
          $sformatf("R2 pending results: actual %0d/%0d expected 0/0", cls_q.size(), rel_q.size()));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule